// File: doc/BRIEF.md
# Clear-On-Read Interrupt Aggregator

This block gathers single-cycle event pulses from up to sixteen groups of eight sources into sixteen 8-bit status registers. A bit is set by its event and stays set until software reads the register that holds it. That read returns the contents and clears the whole register. Each status register has a mask register beside it. The active-low request output `irq_n` is driven low while any unmasked status bit is set. A 16-bit pending vector has one bit per status register, so software can see at once which registers need reading.

A built-in divider produces one tick every `CLK_HZ` clock cycles, which is one second at the real clock rate. The tick sets bit 0 of the last status register. With every other source masked, the block can therefore be used as a periodic timer interrupt while software polls the latched status. A suspend bit in the control register holds `irq_n` high during a long service routine. Latching carries on while the suspend bit is set.

Software reaches all registers through a synchronous bus. Reads return data one cycle after the read strobe. Address map, byte wide:
- `0x00`–`0x0F`: status registers.
- `0x10`–`0x1F`: mask registers.
- `0x20`: vector bits 7..0.
- `0x21`: vector bits 15..8.
- `0x22`: control register.
- Any other address reads as 0.

Top module: `irq_hub`

## Requirements
- R1: A one-cycle pulse on `evt_i[8*r+b]` sets bit b of status register r at the next clock edge. The bit stays set until a read of address r.
- R2: A read of address r (0x00–0x0F) returns the register's contents on `bus_rdata` one cycle after the strobe. The whole register is cleared at the same edge, so an immediate second read returns 0x00.
- R3: If an event pulse arrives in the same cycle as the clearing read of its register, the read returns the old value and the new bit remains set afterwards.
- R4: Vector bit r is 1 exactly when status register r holds a bit whose mask bit is 0. It is read as the low byte at 0x20 and the high byte at 0x21, and reading it clears nothing.
- R5: `irq_n` is 0 while any vector bit is 1 and suspend is off. It returns to 1 once every unmasked status bit has been cleared.
- R6: Mask registers at 0x10+r are readable and writable. A mask bit of 1 keeps its status bit out of the vector and out of `irq_n`, but the status bit still latches.
- R7: Control bit 0 at 0x22 is the suspend bit; 1 means suspend. While it is 1, `irq_n` stays 1 and status latching continues. Clearing it lets a pending request drive `irq_n` low again. The bit reads back.
- R8: The internal divider sets bit 0 of status register 15 once every `CLK_HZ` clock cycles. Reading address 0x0F clears that bit.
- R9: Writes to status addresses 0x00–0x0F change nothing.
- R10: After reset all status, mask and control registers are 0, `irq_n` is 1 and `bus_rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NREG*8 | Event pulses; bit 8*r+b targets status register r, bit b |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; clears a status register when it addresses one |
| bus_addr | input | 6 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench first checks that a read and an event landing on the same register in the same cycle keep the new bit. A design that cleared after latching would silently lose that event. It then checks that masked bits still appear in the status register while staying out of both the vector and `irq_n`; a design that gated the latch with the mask would drop them. It confirms that reading the vector twice gives the same answer, which would not hold if the vector decode shared the status clear path. Finally, it checks that status writes leave existing bits intact, and it measures the exact spacing of two timer ticks so that an off-by-one divider shows up as a wrong cycle count.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
   localparam int unsigned ADDR_W = 6;
   localparam int unsigned DW     = 8;
   localparam logic [ADDR_W-1:0] A_MASK = 6'h10;
   localparam logic [ADDR_W-1:0] A_VEC  = 6'h20;
   localparam logic [ADDR_W-1:0] A_CTL  = 6'h22;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_STAT,
      SEL_MASK,
      SEL_VEC,
      SEL_CTL
   } sel_e;
endpackage

// File: rtl/irq_tick_div.sv
module irq_tick_div #(
   parameter int unsigned CLK_HZ = 100_000_000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int unsigned CW = (CLK_HZ > 2) ? $clog2(CLK_HZ) : 1;
   localparam logic [CW-1:0] LAST = CW'(CLK_HZ - 1);

   logic [CW-1:0] cnt_q;

   generate
      if (CLK_HZ < 2) begin : g_bad_hz
         $error("irq_tick_div: CLK_HZ must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (cnt_q == LAST) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign tick = (cnt_q == LAST);
endmodule

// File: rtl/irq_stat_bank.sv
module irq_stat_bank #(
   parameter int unsigned NREG    = 16,
   parameter int unsigned DW      = 8,
   parameter int unsigned TMR_REG = NREG - 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NREG*DW-1:0]       evt,
   input  logic                     tick,
   input  logic [NREG-1:0]          clr,
   input  logic [NREG-1:0]          mask_we,
   input  logic [DW-1:0]            wdata,
   output logic [NREG-1:0][DW-1:0]  stat,
   output logic [NREG-1:0][DW-1:0]  mask,
   output logic [NREG-1:0]          vec
);
   generate
      if (TMR_REG >= NREG) begin : g_bad_tmr
         $error("irq_stat_bank: TMR_REG out of range");
      end

      for (genvar r = 0; r < NREG; r++) begin : g_reg
         logic [DW-1:0] set_bits;

         if (r == TMR_REG) begin : g_tmr
            assign set_bits = evt[r*DW +: DW] | DW'(tick);
         end else begin : g_plain
            assign set_bits = evt[r*DW +: DW];
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stat[r] <= '0;
            end else begin
               stat[r] <= (clr[r] ? '0 : stat[r]) | set_bits;
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mask[r] <= '0;
            end else if (mask_we[r]) begin
               mask[r] <= wdata;
            end
         end

         assign vec[r] = |(stat[r] & ~mask[r]);
      end
   endgenerate
endmodule

// File: rtl/irq_bus_regs.sv
module irq_bus_regs
   import irq_hub_pkg::*;
#(
   parameter int unsigned NREG = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bus_wr,
   input  logic                     bus_rd,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic [DW-1:0]            bus_wdata,
   input  logic [NREG-1:0][DW-1:0]  stat,
   input  logic [NREG-1:0][DW-1:0]  mask,
   input  logic [NREG-1:0]          vec,
   output logic [NREG-1:0]          clr,
   output logic [NREG-1:0]          mask_we,
   output logic                     susp,
   output logic [DW-1:0]            bus_rdata
);
   localparam int unsigned VBYTES = (NREG + DW - 1) / DW;

   generate
      if (NREG < 1 || NREG > 16) begin : g_bad_nreg
         $error("irq_bus_regs: NREG must be 1..16");
      end
   endgenerate

   sel_e          sel;
   logic [3:0]    idx;
   logic          idx_ok;
   logic [2*DW-1:0] vpad;
   logic [DW-1:0] rd_mux;

   assign idx    = bus_addr[3:0];
   assign idx_ok = (32'(idx) < NREG);
   assign vpad   = (2*DW)'(vec);

   always_comb begin
      sel = SEL_NONE;
      if (bus_addr[ADDR_W-1:4] == 2'b00 && idx_ok) begin
         sel = SEL_STAT;
      end else if (bus_addr[ADDR_W-1:4] == A_MASK[ADDR_W-1:4] && idx_ok) begin
         sel = SEL_MASK;
      end else if (bus_addr == A_VEC || (bus_addr == A_VEC + 6'd1 && VBYTES > 1)) begin
         sel = SEL_VEC;
      end else if (bus_addr == A_CTL) begin
         sel = SEL_CTL;
      end
   end

   generate
      for (genvar r = 0; r < NREG; r++) begin : g_dec
         assign clr[r]     = bus_rd && sel == SEL_STAT && idx == 4'(r);
         assign mask_we[r] = bus_wr && sel == SEL_MASK && idx == 4'(r);
      end
   endgenerate

   always_comb begin
      unique case (sel)
         SEL_STAT: rd_mux = stat[idx];
         SEL_MASK: rd_mux = mask[idx];
         SEL_VEC:  rd_mux = bus_addr[0] ? vpad[2*DW-1:DW] : vpad[DW-1:0];
         SEL_CTL:  rd_mux = {{(DW-1){1'b0}}, susp};
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         susp      <= 1'b0;
         bus_rdata <= '0;
      end else begin
         if (bus_wr && sel == SEL_CTL) begin
            susp <= bus_wdata[0];
         end
         if (bus_rd) begin
            bus_rdata <= rd_mux;
         end
      end
   end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
   import irq_hub_pkg::*;
#(
   parameter int unsigned NREG   = 16,
   parameter int unsigned CLK_HZ = 100_000_000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NREG*8-1:0]  evt_i,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [5:0]         bus_addr,
   input  logic [7:0]         bus_wdata,
   output logic [7:0]         bus_rdata,
   output logic               irq_n
);
   localparam int unsigned TMR_REG = NREG - 1;

   logic                    tick;
   logic [NREG-1:0]         clr;
   logic [NREG-1:0]         mask_we;
   logic [NREG-1:0][DW-1:0] stat;
   logic [NREG-1:0][DW-1:0] mask;
   logic [NREG-1:0]         vec;
   logic                    susp;

   irq_tick_div #(.CLK_HZ(CLK_HZ)) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick)
   );

   irq_stat_bank #(.NREG(NREG), .DW(DW), .TMR_REG(TMR_REG)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt    (evt_i),
      .tick   (tick),
      .clr    (clr),
      .mask_we(mask_we),
      .wdata  (bus_wdata),
      .stat   (stat),
      .mask   (mask),
      .vec    (vec)
   );

   irq_bus_regs #(.NREG(NREG)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_wr   (bus_wr),
      .bus_rd   (bus_rd),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .stat     (stat),
      .mask     (mask),
      .vec      (vec),
      .clr      (clr),
      .mask_we  (mask_we),
      .susp     (susp),
      .bus_rdata(bus_rdata)
   );

   assign irq_n = susp | ~(|vec);
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
   parameter int unsigned NREG    = 16,
   parameter int unsigned TMR_REG = 15
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [NREG*8-1:0]       evt_i,
   input logic                    tick,
   input logic [NREG-1:0]         clr,
   input logic [NREG-1:0][7:0]    stat,
   input logic                    bus_wr,
   input logic [5:0]              bus_addr,
   input logic                    susp,
   input logic                    irq_n
);
   assert_suspend_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
      susp |-> irq_n);

   assert_tick_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> stat[TMR_REG][0]);

   generate
      for (genvar r = 0; r < NREG; r++) begin : g_r
         assert_event_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_i[r*8 +: 8] != 8'h00) |=>
               ((stat[r] & $past(evt_i[r*8 +: 8])) == $past(evt_i[r*8 +: 8])));

         assert_read_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[r] && evt_i[r*8 +: 8] == 8'h00 && !(r == TMR_REG && tick)) |=>
               (stat[r] == 8'h00));

         assert_hold_on_clash_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[r] && evt_i[r*8 +: 8] != 8'h00) |=>
               (stat[r] != 8'h00));

         assert_status_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == 6'(r) && stat[r] == 8'h00 &&
             evt_i[r*8 +: 8] == 8'h00 && !tick) |=> (stat[r] == 8'h00));
      end
   endgenerate
endmodule

bind irq_hub irq_hub_chk #(.NREG(NREG), .TMR_REG(NREG - 1)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .evt_i   (evt_i),
   .tick    (tick),
   .clr     (clr),
   .stat    (stat),
   .bus_wr  (bus_wr),
   .bus_addr(bus_addr),
   .susp    (susp),
   .irq_n   (irq_n)
);

// File: tb/tb_irq_hub.sv
module tb_irq_hub;
   localparam int unsigned NREG = 16;
   localparam int unsigned HZ   = 300;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NREG*8-1:0] evt_i = '0;
   logic              bus_wr = 1'b0;
   logic              bus_rd = 1'b0;
   logic [5:0]        bus_addr = '0;
   logic [7:0]        bus_wdata = '0;
   logic [7:0]        bus_rdata;
   logic              irq_n;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   irq_hub #(.NREG(NREG), .CLK_HZ(HZ)) dut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n)
   );

   // {reg[3:0], events[7:0], mask[7:0], expect_active}
   localparam logic [20:0] TBL [8] = '{
      {4'd0,  8'h01, 8'h00, 1'b1},
      {4'd7,  8'h80, 8'h80, 1'b0},
      {4'd8,  8'h3C, 8'h0C, 1'b1},
      {4'd14, 8'hFF, 8'hFE, 1'b1},
      {4'd3,  8'h10, 8'hEF, 1'b1},
      {4'd10, 8'h42, 8'h42, 1'b0},
      {4'd1,  8'h00, 8'h00, 1'b0},
      {4'd12, 8'h81, 8'h7E, 1'b1}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic pulse(input int r, input logic [7:0] bits);
      @(negedge clk);
      evt_i[r*8 +: 8] = bits;
      @(negedge clk);
      evt_i = '0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] d, d2;
      logic [15:0] v;
      int t0;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 irq_n", irq_n, 1'b1);
      chk("R10 rdata", bus_rdata, 8'h00);
      rst_n = 1'b1;
      rd(6'h05, d);  chk("R10 status", d, 8'h00);
      rd(6'h15, d);  chk("R10 mask", d, 8'h00);
      rd(6'h22, d);  chk("R10 ctl", d, 8'h00);
      // keep the timer bit out of the request for the table
      wr(6'h1F, 8'h01);

      for (int i = 0; i < 8; i++) begin
         logic [3:0] r;
         logic [7:0] ev, mk;
         logic act;
         {r, ev, mk, act} = TBL[i];
         wr(6'h10 + 6'(r), mk);
         pulse(int'(r), ev);
         rd(6'h20, v[7:0]);
         rd(6'h21, v[15:8]);
         chk("R4 vector", v, act ? (16'h1 << r) : 16'h0);
         chk("R5/R6 irq_n", irq_n, !act);
         rd(6'(r), d);
         chk("R1/R6 status latched", d, ev);
         rd(6'(r), d);
         chk("R2 cleared", d, 8'h00);
         chk("R5 irq released", irq_n, 1'b1);
         wr(6'h10 + 6'(r), 8'h00);
      end

      // R4 vector read twice has no side effect
      pulse(2, 8'h04);
      pulse(9, 8'h01);
      rd(6'h20, d);  rd(6'h20, d2);
      chk("R4 vec lo repeat", {d, d2}, 16'h0404);
      rd(6'h21, d);
      chk("R4 vec hi", d, 8'h02);
      rd(6'h02, d);
      chk("R5 irq held by other reg", irq_n, 1'b0);
      rd(6'h09, d);
      chk("R5 irq after all cleared", irq_n, 1'b1);

      // R3 event in the same cycle as the clearing read
      pulse(3, 8'h01);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = 6'h03; evt_i[3*8 + 2] = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0; evt_i = '0;
      chk("R3 old value returned", bus_rdata, 8'h01);
      rd(6'h03, d);
      chk("R3 new bit kept", d, 8'h04);

      // R9 status writes ignored
      wr(6'h04, 8'hFF);
      rd(6'h04, d);
      chk("R9 write to empty status", d, 8'h00);
      pulse(4, 8'h01);
      wr(6'h04, 8'h00);
      rd(6'h04, d);
      chk("R9 write keeps bits", d, 8'h01);

      // R6 mask read/write
      wr(6'h15, 8'hA5);
      rd(6'h15, d);
      chk("R6 mask readback", d, 8'hA5);
      wr(6'h15, 8'h00);

      // R7 suspend
      wr(6'h22, 8'h01);
      rd(6'h22, d);
      chk("R7 ctl readback", d, 8'h01);
      pulse(6, 8'h20);
      chk("R7 irq held high", irq_n, 1'b1);
      rd(6'h20, d);
      chk("R7 latching continues", d, 8'h40);
      wr(6'h22, 8'h00);
      chk("R7 irq after resume", irq_n, 1'b0);
      rd(6'h06, d);
      chk("R7 status", d, 8'h20);

      // R8 timer tick spacing
      wr(6'h1F, 8'h00);
      rd(6'h0F, d);
      while (irq_n) @(negedge clk);
      t0 = cyc;
      rd(6'h0F, d);
      chk("R8 timer bit", d, 8'h01);
      chk("R8 cleared by read", irq_n, 1'b1);
      while (irq_n) @(negedge clk);
      chk("R8 tick period", cyc - t0, HZ);
      rd(6'h0F, d);

      finish_run();
   end
endmodule